// File: doc/BRIEF.md
# Programmable static memory read sequencer

This block runs read cycles on one asynchronous static memory bank (ROM, NOR flash or SRAM). A host raises a request with a word address. The sequencer then steps through a fixed series of phases. It puts the address out, waits, asserts chip select, waits again, asserts output enable for the access window, captures the data word on the last clock of that window, and then releases the strobes with programmed hold gaps. The data goes back to the host with a one-clock ready pulse.

Each phase length comes from a field of a 15-bit timing register. The field codes map to non-linear clock counts, so one register covers both very fast and very slow parts. When page mode is selected, one request yields a burst of 4, 8 or 16 consecutive words. Chip select and output enable stay asserted for the whole burst, and every word after the first uses a shorter page access time. Two strap inputs, bus width and endianness, appear as read-only status outputs.

The timing register comes out of reset at its slowest setting. Software reprograms it for the actual part. For example, 0x1A00 gives zero address setup, a four-clock gap from chip select to output enable, a three-clock access and no hold.

Top module: `smem_read_seq`

## Requirements
- R1: After reset, mem_cs_n and mem_oe_n are 1, mem_addr_valid, busy and ready are 0, mem_addr is 0, and cfg_rdata reads 0x0700 (access code 111, all other fields 0).
- R2: The timing register fields decode as follows. Address setup [14:13], CS-to-OE delay [12:11], CS hold [7:6] and address hold [5:4] use codes 0,1,2,3 for 0,1,2,4 clocks. Access [10:8] uses codes 0..7 for 1,2,3,4,6,8,10,14 clocks. Page access [3:2] uses codes 0..3 for 2,3,4,6 clocks. Page count [1:0] uses codes 0..3 for 1,4,8,16 words.
- R3: A read runs these phases in this order, and each lasts its programmed clock count. First only mem_addr_valid is high (address setup). Then mem_cs_n is low (CS-to-OE delay). Then mem_cs_n and mem_oe_n are both low (access). Then mem_oe_n returns high with mem_cs_n still low (CS hold). Then only mem_addr_valid is high (address hold). The block then returns to idle.
- R4: A phase of zero length takes no clock. busy is high exactly while a read's phases run. A request is accepted only in a clock where busy is low, and a request raised while busy is high is ignored.
- R5: rdata takes mem_rdata on the last clock of each access or page-access window. ready is high for exactly one clock, the clock after that capture, and rdata does not change in clocks where ready is low.
- R6: With page count above one, mem_cs_n and mem_oe_n stay low across all words of the burst, mem_addr increases by one per word (modulo 2^AW), and words after the first take the page access time.
- R7: A timing register write made while busy is high does not change the read in progress. It reads back at once on cfg_rdata and governs the next accepted request.
- R8: bank_width equals width_strap (00 8-bit, 01 16-bit, 10 32-bit, 11 test mode) and bank_big_endian equals endian_strap (1 big endian), in the same clock.
- R9: mem_oe_n is never low unless mem_cs_n is low, and mem_cs_n is never low unless mem_addr_valid is high.
- R10: With timing value 0x1A00, a read keeps busy high for exactly 7 clocks, with output enable low for the last 3 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every phase count is in these clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the timing register |
| cfg_wdata | input | 15 | New timing register value |
| cfg_rdata | output | 15 | Current timing register value |
| width_strap | input | 2 | Bank data width strap |
| endian_strap | input | 1 | Bank endian strap |
| bank_width | output | 2 | Read-only bank width status |
| bank_big_endian | output | 1 | Read-only endian status |
| req | input | 1 | Read request, sampled while idle |
| req_addr | input | AW | Word address of the request |
| busy | output | 1 | A read is in progress |
| ready | output | 1 | One-clock pulse: rdata holds a new word |
| rdata | output | DW | Captured read word |
| mem_addr | output | AW | Address to the memory |
| mem_addr_valid | output | 1 | Address phase strobe |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_rdata | input | DW | Data from the memory |

## Verification
All strobes come straight from the phase state, so a wrong phase or a wrong counter reload shows at the memory pins in the very clock it happens: a strobe edge one clock early or late, or a phase that appears when it should have been skipped. A wrong beat index or a stale timing snapshot shows later. It surfaces as a wrong address during a burst, or as a page word with full access length, and then as a ready pulse shifted by that amount, together with a captured word that does not match the memory contents at the expected address. The bench keeps its own per-clock schedule of expected pin values and compares every clock, so the first divergent clock is reported.

// File: rtl/smem_seq_pkg.sv
package smem_seq_pkg;

   localparam int CFG_W = 15;
   localparam logic [CFG_W-1:0] CFG_RESET = 15'h0700;

   typedef enum logic [2:0] {
      PH_IDLE, PH_ASET, PH_CSET, PH_ACC, PH_PACC, PH_CHOLD, PH_AHOLD
   } phase_e;

   // field order is the bit layout, most significant first
   typedef struct packed {
      logic [1:0] aset;
      logic [1:0] cset;
      logic [2:0] acc;
      logic [1:0] chold;
      logic [1:0] ahold;
      logic [1:0] pacc;
      logic [1:0] pcnt;
   } timing_t;

   function automatic logic [3:0] dec_short(input logic [1:0] c);
      case (c)
         2'd0:    return 4'd0;
         2'd1:    return 4'd1;
         2'd2:    return 4'd2;
         default: return 4'd4;
      endcase
   endfunction

   function automatic logic [3:0] dec_acc(input logic [2:0] c);
      case (c)
         3'd0:    return 4'd1;
         3'd1:    return 4'd2;
         3'd2:    return 4'd3;
         3'd3:    return 4'd4;
         3'd4:    return 4'd6;
         3'd5:    return 4'd8;
         3'd6:    return 4'd10;
         default: return 4'd14;
      endcase
   endfunction

   function automatic logic [3:0] dec_pacc(input logic [1:0] c);
      case (c)
         2'd0:    return 4'd2;
         2'd1:    return 4'd3;
         2'd2:    return 4'd4;
         default: return 4'd6;
      endcase
   endfunction

   // index of the final word in a burst
   function automatic logic [3:0] dec_last(input logic [1:0] c);
      case (c)
         2'd0:    return 4'd0;
         2'd1:    return 4'd3;
         2'd2:    return 4'd7;
         default: return 4'd15;
      endcase
   endfunction

endpackage

// File: rtl/smem_timing_reg.sv
module smem_timing_reg
   import smem_seq_pkg::*;
#(
   parameter bit PAGE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_q
);

   logic [CFG_W-1:0] wval;

   generate
      if (PAGE_EN) begin : g_page
         assign wval = wdata;
      end else begin : g_nopage
         assign wval = {wdata[CFG_W-1:4], 4'b0000};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= CFG_RESET;
      else if (we) cfg_q <= wval;
   end

endmodule

// File: rtl/smem_phase_fsm.sv
module smem_phase_fsm
   import smem_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CFG_W-1:0] cfg_q,
   output phase_e           phase,
   output logic [3:0]       beat_idx,
   output logic             data_end
);

   timing_t snap_q, use_t;
   phase_e  ph_q, ph_d, nxt;
   logic [3:0] cnt_q, cnt_d, idx_q, idx_d;
   logic adv;

   // in idle the live register decides the first phase, afterwards the snapshot
   assign use_t = (ph_q == PH_IDLE) ? timing_t'(cfg_q) : snap_q;

   function automatic logic [3:0] len_of(input phase_e p, input timing_t t);
      case (p)
         PH_ASET:  return dec_short(t.aset);
         PH_CSET:  return dec_short(t.cset);
         PH_ACC:   return dec_acc(t.acc);
         PH_PACC:  return dec_pacc(t.pacc);
         PH_CHOLD: return dec_short(t.chold);
         PH_AHOLD: return dec_short(t.ahold);
         default:  return 4'd0;
      endcase
   endfunction

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      idx_d = idx_q;
      nxt   = PH_IDLE;
      adv   = 1'b0;
      case (ph_q)
         PH_IDLE: begin
            if (req) begin
               adv   = 1'b1;
               idx_d = 4'd0;
               nxt   = (use_t.aset != 2'd0) ? PH_ASET :
                       (use_t.cset != 2'd0) ? PH_CSET : PH_ACC;
            end
         end
         default: begin
            if (cnt_q != 4'd0) begin
               cnt_d = cnt_q - 4'd1;
            end else begin
               adv = 1'b1;
               case (ph_q)
                  PH_ASET: nxt = (use_t.cset != 2'd0) ? PH_CSET : PH_ACC;
                  PH_CSET: nxt = PH_ACC;
                  PH_ACC, PH_PACC: begin
                     if (idx_q != dec_last(use_t.pcnt)) begin
                        nxt   = PH_PACC;
                        idx_d = idx_q + 4'd1;
                     end else begin
                        nxt = (use_t.chold != 2'd0) ? PH_CHOLD :
                              (use_t.ahold != 2'd0) ? PH_AHOLD : PH_IDLE;
                     end
                  end
                  PH_CHOLD: nxt = (use_t.ahold != 2'd0) ? PH_AHOLD : PH_IDLE;
                  default:  nxt = PH_IDLE;
               endcase
            end
         end
      endcase
      if (adv) begin
         ph_d  = nxt;
         cnt_d = (nxt == PH_IDLE) ? 4'd0 : len_of(nxt, use_t) - 4'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= 4'd0;
         idx_q  <= 4'd0;
         snap_q <= timing_t'(CFG_RESET);
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
         idx_q <= idx_d;
         if (ph_q == PH_IDLE && req) snap_q <= timing_t'(cfg_q);
      end
   end

   assign phase    = ph_q;
   assign beat_idx = idx_q;
   assign data_end = (ph_q == PH_ACC || ph_q == PH_PACC) && (cnt_q == 4'd0);

endmodule

// File: rtl/smem_read_seq.sv
module smem_read_seq
   import smem_seq_pkg::*;
#(
   parameter int AW      = 20,
   parameter int DW      = 16,
   parameter bit PAGE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic [1:0]       width_strap,
   input  logic             endian_strap,
   output logic [1:0]       bank_width,
   output logic             bank_big_endian,
   input  logic             req,
   input  logic [AW-1:0]    req_addr,
   output logic             busy,
   output logic             ready,
   output logic [DW-1:0]    rdata,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_addr_valid,
   output logic             mem_cs_n,
   output logic             mem_oe_n,
   input  logic [DW-1:0]    mem_rdata
);

   localparam int BEAT_W = 4;

   generate
      if (AW < BEAT_W + 1) begin : g_bad_aw
         $error("smem_read_seq: AW must cover a 16-word page");
      end
      if (DW < 1) begin : g_bad_dw
         $error("smem_read_seq: DW must be positive");
      end
   endgenerate

   phase_e            phase;
   logic [BEAT_W-1:0] beat_idx;
   logic              data_end;
   logic [AW-1:0]     base_q;
   logic [CFG_W-1:0]  cfg_q;

   smem_timing_reg #(.PAGE_EN(PAGE_EN)) u_treg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg_q (cfg_q)
   );

   smem_phase_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .cfg_q    (cfg_q),
      .phase    (phase),
      .beat_idx (beat_idx),
      .data_end (data_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         rdata  <= '0;
         ready  <= 1'b0;
      end else begin
         if (phase == PH_IDLE && req) base_q <= req_addr;
         if (data_end) rdata <= mem_rdata;
         ready <= data_end;
      end
   end

   assign busy           = (phase != PH_IDLE);
   assign mem_addr_valid = busy;
   assign mem_addr       = busy ? base_q + AW'(beat_idx) : '0;
   assign mem_cs_n       = !(phase == PH_CSET || phase == PH_ACC ||
                             phase == PH_PACC || phase == PH_CHOLD);
   assign mem_oe_n       = !(phase == PH_ACC || phase == PH_PACC);

   assign cfg_rdata       = cfg_q;
   assign bank_width      = width_strap;
   assign bank_big_endian = endian_strap;

endmodule

// File: rtl/smem_read_seq_chk.sv
module smem_read_seq_chk #(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          ready,
   input logic [DW-1:0] rdata,
   input logic [AW-1:0] mem_addr,
   input logic          mem_addr_valid,
   input logic          mem_cs_n,
   input logic          mem_oe_n
);

   assert_oe_inside_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_cs_n);

   assert_cs_inside_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> mem_addr_valid);

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_cs_n && mem_oe_n && !mem_addr_valid));

   assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   assert_ready_after_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> $past(!mem_oe_n));

   assert_rdata_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> $stable(rdata));

   assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && mem_oe_n && $past(!mem_cs_n) && $past(mem_oe_n)) |-> $stable(mem_addr));

endmodule

bind smem_read_seq smem_read_seq_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy           (busy),
   .ready          (ready),
   .rdata          (rdata),
   .mem_addr       (mem_addr),
   .mem_addr_valid (mem_addr_valid),
   .mem_cs_n       (mem_cs_n),
   .mem_oe_n       (mem_oe_n)
);

// File: tb/smem_read_seq_tb.sv
module smem_read_seq_tb;

   localparam int AW = 20;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [14:0]   cfg_wdata = '0;
   logic [14:0]   cfg_rdata;
   logic [1:0]    width_strap = 2'b01;
   logic          endian_strap = 1'b1;
   logic [1:0]    bank_width;
   logic          bank_big_endian;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          busy, ready;
   logic [DW-1:0] rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_addr_valid, mem_cs_n, mem_oe_n;
   logic [DW-1:0] mem_rdata;

   always #2 clk = ~clk;

   function automatic int rom(input int a);
      return ((a * 37) + 16'h05A5) & 16'hFFFF;
   endfunction

   assign mem_rdata = DW'(rom(int'(mem_addr)));

   smem_read_seq #(.AW(AW), .DW(DW)) u_dut (.*);

   int n_chk = 0, n_err = 0;
   bit done = 0;
   string sect = "R3";

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   typedef struct { bit cs; bit oe; bit av; int addr; bit rdy; int rd; } ent_t;
   ent_t q[$];
   bit   tail_rdy = 0, pend_rdy = 0;
   int   tail_rd = 0, pend_rd = 0;
   int   mcfg = 15'h0700;
   int   n_busy = 0, n_rdy = 0, n_oe = 0;

   int shortv[4] = '{0, 1, 2, 4};
   int accv[8]   = '{1, 2, 3, 4, 6, 8, 10, 14};
   int paccv[4]  = '{2, 3, 4, 6};
   int beatv[4]  = '{1, 4, 8, 16};

   function automatic void push(input bit cs, input bit oe, input int addr);
      ent_t e;
      e.cs = cs; e.oe = oe; e.av = 1; e.addr = addr & ((1 << AW) - 1);
      e.rdy = pend_rdy; e.rd = pend_rd; pend_rdy = 0;
      q.push_back(e);
   endfunction

   function automatic void build(input int base, input int cfg);
      int as = shortv[(cfg >> 13) & 3];
      int cst = shortv[(cfg >> 11) & 3];
      int ac = accv[(cfg >> 8) & 7];
      int ch = shortv[(cfg >> 6) & 3];
      int ah = shortv[(cfg >> 4) & 3];
      int pa = paccv[(cfg >> 2) & 3];
      int nb = beatv[cfg & 3];
      for (int i = 0; i < as; i++) push(0, 0, base);
      for (int i = 0; i < cst; i++) push(1, 0, base);
      for (int w = 0; w < nb; w++) begin
         int len = (w == 0) ? ac : pa;
         for (int k = 0; k < len; k++) push(1, 1, base + w);
         pend_rdy = 1;
         pend_rd = rom((base + w) & ((1 << AW) - 1));
      end
      for (int i = 0; i < ch; i++) push(1, 0, base + nb - 1);
      for (int i = 0; i < ah; i++) push(0, 0, base + nb - 1);
      if (pend_rdy) begin
         tail_rdy = 1; tail_rd = pend_rd; pend_rdy = 0;
      end
   endfunction

   // reference model, compared every clock away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         ent_t e;
         bit was_idle;
         was_idle = (q.size() == 0);
         if (!was_idle) e = q.pop_front();
         else begin
            e.cs = 0; e.oe = 0; e.av = 0; e.addr = 0; e.rdy = tail_rdy; e.rd = tail_rd;
            tail_rdy = 0;
         end
         chk(mem_cs_n == !e.cs && mem_oe_n == !e.oe && mem_addr_valid == e.av, sect, "strobes cs/oe/av",
             {mem_cs_n, mem_oe_n, mem_addr_valid}, {!e.cs, !e.oe, e.av});
         chk(int'(mem_addr) == e.addr, sect, "mem_addr", int'(mem_addr), e.addr);
         chk(busy == !was_idle, "R4", "busy", busy, !was_idle);
         chk(ready == e.rdy, "R5", "ready", ready, e.rdy);
         if (e.rdy) chk(int'(rdata) == e.rd, "R5", "rdata", int'(rdata), e.rd);
         chk(!(!mem_oe_n && mem_cs_n) && !(!mem_cs_n && !mem_addr_valid), "R9", "strobe nesting",
             {mem_cs_n, mem_oe_n, mem_addr_valid}, 0);
         if (busy) n_busy++;
         if (ready) n_rdy++;
         if (!mem_oe_n) n_oe++;
         if (was_idle && req) build(int'(req_addr), mcfg);
         if (cfg_we) mcfg = int'(cfg_wdata);
      end
   end

   task automatic wcfg(input int v);
      @(posedge clk); #1 cfg_we = 1; cfg_wdata = 15'(v);
      @(posedge clk); #1 cfg_we = 0;
   endtask

   task automatic rd(input int a);
      @(posedge clk); #1 req = 1; req_addr = AW'(a);
      @(posedge clk); #1 req = 0;
   endtask

   task automatic wait_idle();
      @(posedge clk);
      while (q.size() != 0 || tail_rdy) @(posedge clk);
      repeat (2) @(posedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int b0, r0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(mem_cs_n && mem_oe_n && !mem_addr_valid && !busy && !ready && mem_addr == 0, "R1", "idle pins",
          {mem_cs_n, mem_oe_n, mem_addr_valid, busy, ready}, 5'b11000);
      chk(cfg_rdata == 15'h0700, "R1", "cfg reset", cfg_rdata, 15'h0700);
      // R8 strap status
      chk(bank_width == 2'b01 && bank_big_endian == 1'b1, "R8", "status 16-bit big",
          {bank_width, bank_big_endian}, 3'b011);
      @(posedge clk); #1 rst_n = 1;
      width_strap = 2'b11; endian_strap = 0;
      @(negedge clk);
      chk(bank_width == 2'b11 && bank_big_endian == 1'b0, "R8", "status test little",
          {bank_width, bank_big_endian}, 3'b110);

      // R2/R3 slowest reset timing
      sect = "R3";
      rd(20'h00100); wait_idle();

      // R10 worked example
      sect = "R10";
      wcfg(15'h1A00);
      b0 = n_busy; r0 = n_oe;
      rd(20'h00234); wait_idle();
      chk(n_busy - b0 == 7, "R10", "busy clocks", n_busy - b0, 7);
      chk(n_oe - r0 == 3, "R10", "oe clocks", n_oe - r0, 3);

      // R2 code sweep over all short, access and hold codes
      sect = "R2";
      for (int c = 0; c < 8; c++) begin
         int v = ((c & 3) << 13) | (((c + 1) & 3) << 11) | (c << 8) |
                 (((c + 2) & 3) << 6) | (((c + 3) & 3) << 4);
         wcfg(v); rd(20'h01000 + c * 3); wait_idle();
      end

      // R6 page bursts, every page count and page access code, with wrap at the top
      sect = "R6";
      for (int p = 1; p < 4; p++) begin
         wcfg((1 << 13) | (1 << 11) | (2 << 8) | (1 << 6) | (2 << 4) | (p << 2) | p);
         b0 = n_rdy;
         rd(20'h02000 + p * 40); wait_idle();
         chk(n_rdy - b0 == beatv[p], "R6", "words per burst", n_rdy - b0, beatv[p]);
      end
      wcfg(15'h0001); rd(20'hFFFFE); wait_idle();

      // R4 all-zero phases, back-to-back requests held high, ignored request
      sect = "R4";
      wcfg(15'h0000);
      @(posedge clk); #1 req = 1; req_addr = 20'h00777;
      repeat (6) @(posedge clk); #1 req = 0;
      wait_idle();
      wcfg(15'h0700);
      b0 = n_rdy;
      rd(20'h00300);
      repeat (4) @(posedge clk);
      rd(20'h00999);
      wait_idle();
      chk(n_rdy - b0 == 1, "R4", "request during busy ignored", n_rdy - b0, 1);

      // R7 write during busy affects only the next read
      sect = "R7";
      wcfg(15'h7F00);
      rd(20'h00400);
      repeat (3) @(posedge clk);
      wcfg(15'h0200);
      @(negedge clk);
      chk(cfg_rdata == 15'h0200, "R7", "readback of new value", cfg_rdata, 15'h0200);
      wait_idle();
      b0 = n_busy;
      rd(20'h00401); wait_idle();
      chk(n_busy - b0 == 3, "R7", "next read uses new timing", n_busy - b0, 3);

      finish_run();
   end

endmodule